// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the general-purpose register storage of a 32-bit RISC core that runs in several operating modes. Software names registers with 4-bit logical indices. Depending on the active mode, some indices select a private physical copy instead of the shared one. The block has two combinational read ports and one write port. It also holds the current status word and one saved status word for each exception mode.

The active mode is the low five bits of the current status word. Entering an exception saves the status word, stores the return address and changes the mode in one clock edge. A restore strobe returns to the saved status word. Index 15 is the program counter. The core supplies that value on an input, and a write to index 15 becomes a branch request. Reset puts the file in supervisor mode with every register cleared.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every general register reads zero, every saved status word is zero, and the status word is 0x00000013 (supervisor).
- R2: Logical R0–R7 name the same physical registers in every mode.
- R3: Fast-interrupt mode (code 10001) has private copies of R8–R14. Writes made in that mode are invisible from the other modes, and the reverse also holds.
- R4: Interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each have private R13 and R14 only. Their R8–R12 are the shared ones.
- R5: User mode (10000), system mode (11111) and any unlisted mode code use the shared bank and have no saved status word. In those modes `savedOut` reads zero.
- R6: Reading index 15 returns `pcIn`. Writing index 15 raises `branchReq` in the same cycle, with `branchAddr` equal to the write data, and stores nothing. `branchAddr` is zero when there is no request.
- R7: When a read index (0–14) equals the write index while `wrEn` is high, that read port returns `wrData` in the same cycle.
- R8: An `excEnter` with one of the five exception mode codes does three things on the next clock edge. It stores the old status word into that mode's saved slot, writes `excRetAddr` into that mode's R14, and sets status bits [4:0] to the mode code while keeping the upper bits. A target code outside those five has no effect. If an ordinary write hits the same physical register, the return address wins.
- R9: `restoreReq` copies the current mode's saved status word into the status word. In a mode without a saved slot it has no effect.
- R10: `statusWr` loads `statusWrData` into the status word. When several status updates arrive in one cycle, an effective exception entry takes priority, then an effective restore, then the direct write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdIdxA | input | 4 | Logical index, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdIdxB | input | 4 | Logical index, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrIdx | input | 4 | Logical write index |
| wrData | input | 32 | Write data |
| pcIn | input | 32 | Program counter value returned for index 15 |
| branchReq | output | 1 | Write to index 15 seen |
| branchAddr | output | 32 | Branch target while branchReq is high, else zero |
| excEnter | input | 1 | Exception entry strobe |
| excMode | input | 5 | Target mode code for exception entry |
| excRetAddr | input | 32 | Return address written to the target R14 |
| restoreReq | input | 1 | Copy the current saved status word back |
| statusWr | input | 1 | Direct status word write |
| statusWrData | input | 32 | Data for the direct status write |
| statusOut | output | 32 | Current status word |
| savedOut | output | 32 | Saved status word of the current mode, zero if none |

## Verification
The bench goes after bank isolation. A value written in supervisor mode must be replaced by a fresh zero R13 after a switch to user mode, and it must come back after the switch back. A file that shared those registers, or that banked R8–R12 outside fast-interrupt mode, would return the wrong value. Exception entry is checked on all three effects at once, so a design that saved the status after changing the mode, or that put the return address into the wrong bank, shows a mismatch. The bench also checks that a restore is dropped in a mode without a saved slot, that three status requests in one cycle resolve in the stated priority, and that reads bypass the write data. Random traffic across all mode codes, including an unlisted one, then compares every output against a bench model in every cycle.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int MODE_W   = 5;
  localparam int IDX_W    = 4;
  localparam int NUM_RD   = 2;
  localparam int PC_IDX   = (1 << IDX_W) - 1;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // Physical layout: shared R0-R14, then fast-interrupt R8-R14,
  // then a pair (R13, R14) for each of the four other exception modes.
  localparam int NUM_SHARED  = PC_IDX;
  localparam int FIQ_FIRST   = 8;
  localparam int FIQ_BANKED  = NUM_SHARED - FIQ_FIRST;
  localparam int PAIR_FIRST  = 13;
  localparam int PAIR_SIZE   = NUM_SHARED - PAIR_FIRST;
  localparam int NUM_PAIRED  = 4;
  localparam int NUM_PHYS    = NUM_SHARED + FIQ_BANKED + NUM_PAIRED * PAIR_SIZE;
  localparam int NUM_SAVED   = NUM_PAIRED + 1;
  localparam int PHYS_W      = $clog2(NUM_PHYS);
  localparam int SLOT_W      = $clog2(NUM_SAVED + 1);
  localparam logic [SLOT_W-1:0] NO_SLOT = '1;

  typedef logic [PHYS_W-1:0] physIdx_t;
  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [1:0] {
    CPSR_HOLD,
    CPSR_FROM_EXC,
    CPSR_FROM_SAVED,
    CPSR_FROM_WRITE
  } cpsrSrc_t;

  typedef struct packed {
    logic                      gpWe;
    physIdx_t                  gpPhys;
    logic                      lrWe;
    physIdx_t                  lrPhys;
    logic                      saveWe;
    slot_t                     saveSlot;
    cpsrSrc_t                  cpsrSrc;
    slot_t                     curSlot;
    logic [NUM_RD-1:0]         rdPc;
    logic [NUM_RD-1:0][IDX_W-1:0] rdIdx;
    logic [NUM_RD-1:0][PHYS_W-1:0] rdPhys;
  } ctrlStrobes_t;

  // Saved-status slot of a mode; fast interrupt is slot 0.
  function automatic slot_t savedSlot(input logic [MODE_W-1:0] m);
    case (m)
      MODE_FIQ: return slot_t'(0);
      MODE_IRQ: return slot_t'(1);
      MODE_SVC: return slot_t'(2);
      MODE_ABT: return slot_t'(3);
      MODE_UND: return slot_t'(4);
      default:  return NO_SLOT;
    endcase
  endfunction

  function automatic physIdx_t mapIndex(input logic [MODE_W-1:0] m,
                                        input logic [IDX_W-1:0] idx);
    int p;
    int s;
    p = int'(idx);
    s = int'(savedSlot(m));
    if (m == MODE_FIQ && p >= FIQ_FIRST && p < NUM_SHARED)
      p = NUM_SHARED + p - FIQ_FIRST;
    else if (p >= PAIR_FIRST && p < NUM_SHARED && s >= 1 && s <= NUM_PAIRED)
      p = NUM_SHARED + FIQ_BANKED + (s - 1) * PAIR_SIZE + (p - PAIR_FIRST);
    return physIdx_t'(p);
  endfunction

endpackage

// File: rtl/bankreg_ctrl.sv
module bankreg_ctrl
  import bankreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MODE_W-1:0]    curMode,
  input  logic [IDX_W-1:0]     rdIdxA,
  input  logic [IDX_W-1:0]     rdIdxB,
  input  logic                 wrEn,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic                 excEnter,
  input  logic [MODE_W-1:0]    excMode,
  input  logic                 restoreReq,
  input  logic                 statusWr,
  output ctrlStrobes_t         strb,
  output logic                 branchReq
);

  logic [NUM_RD-1:0][IDX_W-1:0] rdIdxVec;
  slot_t  excSlot;
  logic   excValid;
  logic   restoreValid;

  assign rdIdxVec[0] = rdIdxA;
  assign rdIdxVec[1] = rdIdxB;

  assign excSlot      = savedSlot(excMode);
  assign excValid     = excEnter && (excSlot != NO_SLOT);
  assign branchReq    = wrEn && (wrIdx == IDX_W'(PC_IDX));

  always_comb begin
    strb.curSlot  = savedSlot(curMode);
    restoreValid  = restoreReq && (strb.curSlot != NO_SLOT);

    strb.gpWe     = wrEn && (wrIdx != IDX_W'(PC_IDX));
    strb.gpPhys   = mapIndex(curMode, wrIdx);
    strb.lrWe     = excValid;
    strb.lrPhys   = mapIndex(excMode, IDX_W'(NUM_SHARED - 1));
    strb.saveWe   = excValid;
    strb.saveSlot = excSlot;

    if (excValid)          strb.cpsrSrc = CPSR_FROM_EXC;
    else if (restoreValid) strb.cpsrSrc = CPSR_FROM_SAVED;
    else if (statusWr)     strb.cpsrSrc = CPSR_FROM_WRITE;
    else                   strb.cpsrSrc = CPSR_HOLD;
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdMap
    assign strb.rdIdx[p]  = rdIdxVec[p];
    assign strb.rdPc[p]   = (rdIdxVec[p] == IDX_W'(PC_IDX));
    assign strb.rdPhys[p] = mapIndex(curMode, rdIdxVec[p]);
  end

  // R8: an effective exception entry moves the mode to the target code
  a_r8_mode_switch: assert property (@(posedge clk) disable iff (!rstN)
    excEnter && (savedSlot(excMode) != NO_SLOT) |=> curMode == $past(excMode));

  // R9: restore in a mode without a saved slot leaves the mode alone
  a_r9_restore_ignored: assert property (@(posedge clk) disable iff (!rstN)
    restoreReq && !excEnter && !statusWr && (savedSlot(curMode) == NO_SLOT)
    |=> $stable(curMode));

  // R3: fast-interrupt writes to R8-R14 never land in the shared bank
  a_r3_fiq_private: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_FIQ) && wrEn && (wrIdx >= IDX_W'(FIQ_FIRST)) &&
    (wrIdx < IDX_W'(PC_IDX)) |-> strb.gpPhys >= PHYS_W'(NUM_SHARED));

endmodule

// File: rtl/bankreg_dp.sv
module bankreg_dp
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               strb,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [DATA_W-1:0]          excRetAddr,
  input  logic [MODE_W-1:0]          excMode,
  input  logic [DATA_W-1:0]          statusWrData,
  input  logic [DATA_W-1:0]          pcIn,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData,
  output logic [DATA_W-1:0]          cpsrOut,
  output logic [DATA_W-1:0]          savedOut
);

  logic [DATA_W-1:0] gpReg    [NUM_PHYS];
  logic [DATA_W-1:0] savedReg [NUM_SAVED];
  logic [DATA_W-1:0] cpsrReg;
  logic [DATA_W-1:0] cpsrNext;
  logic              lrCollide;

  assign lrCollide = strb.lrWe && (strb.lrPhys == strb.gpPhys);
  assign cpsrOut   = cpsrReg;
  assign savedOut  = (strb.curSlot < slot_t'(NUM_SAVED)) ? savedReg[strb.curSlot] : '0;

  always_comb begin
    case (strb.cpsrSrc)
      CPSR_FROM_EXC:   cpsrNext = {cpsrReg[DATA_W-1:MODE_W], excMode};
      CPSR_FROM_SAVED: cpsrNext = savedOut;
      CPSR_FROM_WRITE: cpsrNext = statusWrData;
      default:         cpsrNext = cpsrReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PHYS; i++)  gpReg[i]    <= '0;
      for (int i = 0; i < NUM_SAVED; i++) savedReg[i] <= '0;
      cpsrReg <= DATA_W'(MODE_SVC);
    end else begin
      if (strb.gpWe && !lrCollide) gpReg[strb.gpPhys] <= wrData;
      if (strb.lrWe)               gpReg[strb.lrPhys] <= excRetAddr;
      if (strb.saveWe && strb.saveSlot < slot_t'(NUM_SAVED))
        savedReg[strb.saveSlot] <= cpsrReg;
      cpsrReg <= cpsrNext;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rdPort
    always_comb begin
      if (strb.rdPc[p])
        rdData[p] = pcIn;
      else if (strb.gpWe && strb.rdPhys[p] == strb.gpPhys)
        rdData[p] = wrData;
      else
        rdData[p] = gpReg[strb.rdPhys[p]];
    end

    // R6: index 15 always reads the program counter input
    a_r6_pc_read: assert property (@(posedge clk) disable iff (!rstN)
      strb.rdPc[p] |-> rdData[p] == pcIn);
  end

  // R8: the target saved slot receives the status word from before entry
  a_r8_status_saved: assert property (@(posedge clk) disable iff (!rstN)
    strb.cpsrSrc == CPSR_FROM_EXC |=> savedOut == $past(cpsrReg));

  // R9: an effective restore brings back the saved word
  a_r9_restore_copy: assert property (@(posedge clk) disable iff (!rstN)
    strb.cpsrSrc == CPSR_FROM_SAVED |=> cpsrReg == $past(savedOut));

  // R10: a direct status write lands unchanged
  a_r10_status_write: assert property (@(posedge clk) disable iff (!rstN)
    strb.cpsrSrc == CPSR_FROM_WRITE |=> cpsrReg == $past(statusWrData));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcIn,
  output logic              branchReq,
  output logic [DATA_W-1:0] branchAddr,
  input  logic              excEnter,
  input  logic [4:0]        excMode,
  input  logic [DATA_W-1:0] excRetAddr,
  input  logic              restoreReq,
  input  logic              statusWr,
  input  logic [DATA_W-1:0] statusWrData,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] savedOut
);

  ctrlStrobes_t                 strb;
  logic [NUM_RD-1:0][DATA_W-1:0] rdData;

  bankreg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .curMode    (statusOut[MODE_W-1:0]),
    .rdIdxA     (rdIdxA),
    .rdIdxB     (rdIdxB),
    .wrEn       (wrEn),
    .wrIdx      (wrIdx),
    .excEnter   (excEnter),
    .excMode    (excMode),
    .restoreReq (restoreReq),
    .statusWr   (statusWr),
    .strb       (strb),
    .branchReq  (branchReq)
  );

  bankreg_dp #(.DATA_W(DATA_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (wrData),
    .excRetAddr   (excRetAddr),
    .excMode      (excMode),
    .statusWrData (statusWrData),
    .pcIn         (pcIn),
    .rdData       (rdData),
    .cpsrOut      (statusOut),
    .savedOut     (savedOut)
  );

  assign rdDataA    = rdData[0];
  assign rdDataB    = rdData[1];
  assign branchAddr = branchReq ? wrData : '0;

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  rdIdxA, rdIdxB, wrIdx;
  logic [31:0] rdDataA, rdDataB, wrData, pcIn, branchAddr;
  logic        wrEn, branchReq, excEnter, restoreReq, statusWr;
  logic [4:0]  excMode;
  logic [31:0] excRetAddr, statusWrData, statusOut, savedOut;

  int checks = 0;
  int errors = 0;

  logic [31:0] mGp [30];
  logic [31:0] mSaved [5];
  logic [31:0] mCpsr;

  always #10 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rstN(rstN),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData), .pcIn(pcIn),
    .branchReq(branchReq), .branchAddr(branchAddr),
    .excEnter(excEnter), .excMode(excMode), .excRetAddr(excRetAddr),
    .restoreReq(restoreReq), .statusWr(statusWr), .statusWrData(statusWrData),
    .statusOut(statusOut), .savedOut(savedOut)
  );

  function automatic int slotOf(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic int physOf(input logic [4:0] m, input int i);
    int s;
    s = slotOf(m);
    if (i < 8) return i;
    if (s == 0) return 15 + i - 8;
    if (i >= 13 && s > 0) return 20 + 2 * s + (i - 13);
    return i;
  endfunction

  function automatic logic [31:0] expRead(input int idx);
    if (idx == 15) return pcIn;
    if (wrEn && int'(wrIdx) == idx) return wrData;
    return mGp[physOf(mCpsr[4:0], idx)];
  endfunction

  function automatic string readTag(input int idx);
    int s;
    s = slotOf(mCpsr[4:0]);
    if (idx == 15) return "R6";
    if (wrEn && int'(wrIdx) == idx) return "R7";
    if (idx < 8) return "R2";
    if (s == 0) return "R3";
    if (s > 0) return "R4";
    return "R5";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    wrEn = 0; wrIdx = 0; wrData = 0;
    excEnter = 0; excMode = 0; excRetAddr = 0;
    restoreReq = 0; statusWr = 0; statusWrData = 0;
  endtask

  task automatic peek(input int idx, input logic [31:0] exp, input string tag);
    rdIdxA = 4'(idx);
    #1;
    chk(tag, rdDataA, exp);
  endtask

  // Check every output against the model, then advance one clock.
  task automatic cycle();
    logic [31:0] nextCpsr;
    int s, cs;
    #5;
    chk(readTag(int'(rdIdxA)), rdDataA, expRead(int'(rdIdxA)));
    chk(readTag(int'(rdIdxB)), rdDataB, expRead(int'(rdIdxB)));
    chk("R6", {31'b0, branchReq}, {31'b0, wrEn && wrIdx == 4'd15});
    chk("R6", branchAddr, (wrEn && wrIdx == 4'd15) ? wrData : 32'h0);
    chk("R10", statusOut, mCpsr);
    cs = slotOf(mCpsr[4:0]);
    chk(cs < 0 ? "R5" : "R9", savedOut, cs < 0 ? 32'h0 : mSaved[cs]);
    @(posedge clk);
    s = slotOf(excMode);
    nextCpsr = mCpsr;
    if (excEnter && s >= 0) begin
      mSaved[s] = mCpsr;
      nextCpsr = {mCpsr[31:5], excMode};
    end else if (restoreReq && cs >= 0) nextCpsr = mSaved[cs];
    else if (statusWr) nextCpsr = statusWrData;
    if (wrEn && wrIdx != 4'd15) mGp[physOf(mCpsr[4:0], int'(wrIdx))] = wrData;
    if (excEnter && s >= 0) mGp[physOf(excMode, 14)] = excRetAddr;
    mCpsr = nextCpsr;
    @(negedge clk);
  endtask

  task automatic setStatus(input logic [31:0] v);
    idle(); statusWr = 1; statusWrData = v; cycle(); idle();
  endtask

  task automatic writeReg(input int idx, input logic [31:0] v);
    idle(); wrEn = 1; wrIdx = 4'(idx); wrData = v; cycle(); idle();
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [4:0] modeTab [8];

  initial begin
    modeTab[0] = 5'b10000; modeTab[1] = 5'b10001; modeTab[2] = 5'b10010;
    modeTab[3] = 5'b10011; modeTab[4] = 5'b10111; modeTab[5] = 5'b11011;
    modeTab[6] = 5'b11111; modeTab[7] = 5'b10100;
    void'($urandom(32'd2024));
    rstN = 0; idle(); rdIdxA = 0; rdIdxB = 0; pcIn = 32'h0;
    for (int i = 0; i < 30; i++) mGp[i] = '0;
    for (int i = 0; i < 5; i++) mSaved[i] = '0;
    mCpsr = 32'h13;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 15; i++) peek(i, 32'h0, "R1");
    chk("R1", statusOut, 32'h13);
    chk("R1", savedOut, 32'h0);

    // R4: supervisor R13 is private against user R13
    writeReg(13, 32'hAAAA_0013);
    setStatus(32'h10);
    peek(13, 32'h0, "R4");
    writeReg(13, 32'hBBBB_0010);
    writeReg(10, 32'h0000_1010);
    setStatus(32'h13);
    peek(13, 32'hAAAA_0013, "R4");
    peek(10, 32'h0000_1010, "R4");

    // R8, R3: fast-interrupt entry then restore
    writeReg(9, 32'h99);
    excEnter = 1; excMode = 5'b10001; excRetAddr = 32'h400;
    wrEn = 1; wrIdx = 4'd14; wrData = 32'hDEAD;
    cycle(); idle();
    chk("R8", statusOut, 32'h11);
    chk("R8", savedOut, 32'h13);
    peek(14, 32'h400, "R8");
    peek(9, 32'h0, "R3");
    peek(2, 32'h0, "R2");
    writeReg(9, 32'hF9);
    restoreReq = 1; cycle(); idle();
    chk("R9", statusOut, 32'h13);
    peek(9, 32'h99, "R3");
    peek(14, 32'hDEAD, "R8");

    // R9: restore ignored in user mode
    setStatus(32'hA000_0010);
    restoreReq = 1; cycle(); idle();
    chk("R9", statusOut, 32'hA000_0010);
    chk("R5", savedOut, 32'h0);

    // R5: system mode shares the user bank
    setStatus(32'h1F);
    writeReg(13, 32'h5151);
    setStatus(32'h10);
    peek(13, 32'h5151, "R5");

    // R6: program counter slot
    pcIn = 32'h1234;
    peek(15, 32'h1234, "R6");
    wrEn = 1; wrIdx = 4'd15; wrData = 32'h800;
    #1;
    chk("R6", {31'b0, branchReq}, 32'h1);
    chk("R6", branchAddr, 32'h800);
    cycle(); idle();
    peek(15, 32'h1234, "R6");

    // R7: write-first bypass
    wrEn = 1; wrIdx = 4'd3; wrData = 32'h3333;
    peek(3, 32'h3333, "R7");
    cycle(); idle();

    // R8: entry toward a mode with no saved slot is ignored
    excEnter = 1; excMode = 5'b10000; excRetAddr = 32'h77;
    cycle(); idle();
    chk("R8", statusOut, 32'h10);
    peek(14, 32'h0, "R8");

    // R10: priority among status updates
    excEnter = 1; excMode = 5'b10010; excRetAddr = 32'h500;
    restoreReq = 1; statusWr = 1; statusWrData = 32'h1B;
    cycle(); idle();
    chk("R10", statusOut, 32'h12);
    restoreReq = 1; statusWr = 1; statusWrData = 32'h17;
    cycle(); idle();
    chk("R10", statusOut, 32'h10);

    // Random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      idle();
      r = int'($urandom % 64);
      rdIdxA = 4'($urandom); rdIdxB = 4'($urandom);
      pcIn = $urandom;
      wrEn = $urandom % 2 == 0;
      wrIdx = (r < 4) ? rdIdxA : 4'($urandom);
      wrData = $urandom;
      excEnter = (r % 12 == 5);
      excMode = modeTab[$urandom % 8];
      excRetAddr = $urandom;
      restoreReq = (r % 10 == 3);
      statusWr = (r % 9 == 1);
      statusWrData = {27'($urandom), modeTab[$urandom % 8]};
      cycle();
    end
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule